// File: doc/BRIEF.md
# Power-Up Initialization Window Controller

This block governs the start-up period of a processor device after its reset is released. At the reset release it takes a snapshot of the external PLL configuration strap pins and presents it at once to the clock generator. It then keeps the clock enable toward the internal subsystems low while a counter measures a fixed initialization window. The window gives the PLL time to lock and the registers time to load their defaults.

While the window is running, every write request from the control-port decoder is refused. The refusal is reported as a one-cycle reject pulse and also recorded in a sticky error flag. When the window has run its full length, the block raises a done flag and opens the subsystem clock enable. From then on, write requests are accepted. Reset can be asserted again at any time. It stops the count, drops done, closes the clock enable and clears the error flag. The snapshot of the straps is kept until the next release.

The window length is specified as a time, 10 ms by default, together with the reference clock frequency. The number of clock cycles is derived from these two values.

Top module: `init_window_ctrl`

## Requirements
- R1: At the first clock edge where `rst` is sampled low after an edge where it was sampled high, `pll_cfg_o` loads `pll_strap_i`. The new value is visible right after that edge.
- R2: `init_done_o` goes high at the INIT_CYCLES-th consecutive clock edge with `rst` low, counted from the release edge. It stays low before that edge. Once high, it stays high until `rst` is asserted. INIT_CYCLES is CLK_HZ*INIT_US/1,000,000.
- R3: `sub_clk_en_o` is low whenever `init_done_o` is low and high whenever `init_done_o` is high.
- R4: A `wr_req_i` sampled high at an edge where `init_done_o` was already high gives `wr_accept_o` high for the one following cycle, and `wr_reject_o` stays low.
- R5: A `wr_req_i` sampled high at an edge where `rst` is low and `init_done_o` is low gives `wr_reject_o` high for the one following cycle, and `wr_accept_o` stays low.
- R6: `wr_err_o` is set by every rejected write. It remains set until `rst` is sampled high, and accepted writes do not clear it.
- R7: Outside the release edge, changes on `pll_strap_i` are ignored. `pll_cfg_o` keeps its value, including through a later reset, until the next release edge.
- R8: An edge with `rst` high clears `init_done_o`, `sub_clk_en_o`, `wr_accept_o`, `wr_reject_o`, `wr_err_o` and the count. A write requested during reset gives neither accept nor reject. A release after a reset that cuts a count short starts a full new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the window |
| pll_strap_i | input | STRAP_W | External PLL configuration strap pins |
| wr_req_i | input | 1 | Write-request strobe from the control-port decoder |
| pll_cfg_o | output | STRAP_W | Captured PLL configuration |
| init_done_o | output | 1 | Initialization window complete |
| sub_clk_en_o | output | 1 | Master clock enable toward the subsystems |
| wr_accept_o | output | 1 | One-cycle pulse: write accepted |
| wr_reject_o | output | 1 | One-cycle pulse: write refused during the window |
| wr_err_o | output | 1 | Sticky flag: a write was refused since the last reset |

## Verification
Every output of this block is a register, so a wrong internal state appears at the ports at the very next clock edge. A counter that is off by one moves the rising edge of `init_done_o` and `sub_clk_en_o` by exactly one cycle. It also turns the accept or reject pulse of a write placed next to the boundary into the other pulse. A strap register that loads at the wrong moment shows a changed `pll_cfg_o` one cycle after the pins move. An error flag that is cleared too early or too late shows on `wr_err_o` in the cycle after the offending edge. The bench compares all outputs on every cycle, so each of these faults is caught on the first cycle in which it shows.

// File: rtl/init_window_pkg.sv
package init_window_pkg;

  // Registered response of the write gate
  typedef struct packed {
    logic accept;
    logic reject;
  } wr_resp_t;

  // Window length in clock cycles, never below 2 so the counter has a width
  function automatic int unsigned cycles_for(input longint unsigned hz,
                                             input longint unsigned us);
    longint unsigned c;
    c = (hz * us) / 64'd1_000_000;
    if (c < 64'd2) c = 64'd2;
    return int'(c[31:0]);
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] pins_i,
  output logic [STRAP_W-1:0] cfg_o
);

  logic rst_d;
  logic release_edge;

  assign release_edge = !rst && rst_d;

  // Remember the reset level from the previous edge
  always_ff @(posedge clk) begin
    rst_d <= rst;
  end

  // Not reset on purpose: the snapshot survives until the next release
  always_ff @(posedge clk) begin
    if (release_edge) cfg_o <= pins_i;
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(release_edge) |-> $stable(cfg_o)); // R7

endmodule

// File: rtl/init_timer.sv
module init_timer #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  output logic done_o,
  output logic last_o
);

  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign last_o = !done_o && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt == LAST) done_o <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2

  AST_DONE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(cnt) == LAST); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o); // R2

endmodule

// File: rtl/write_gate.sv
module write_gate
  import init_window_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_req_i,
  input  logic     done_i,
  output wr_resp_t resp_o,
  output logic     err_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_o <= '0;
      err_o  <= 1'b0;
    end else begin
      resp_o.accept <= wr_req_i &&  done_i;
      resp_o.reject <= wr_req_i && !done_i;
      if (wr_req_i && !done_i) err_o <= 1'b1;
    end
  end

  AST_ACCEPT_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    resp_o.accept |-> $past(done_i)); // R4

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(resp_o.accept && resp_o.reject)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R6

  AST_REJECT_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    resp_o.reject |-> err_o); // R6

endmodule

// File: rtl/init_window_ctrl.sv
module init_window_ctrl
  import init_window_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 200_000_000,
  parameter longint unsigned INIT_US = 10_000,
  parameter int unsigned     STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] pll_strap_i,
  input  logic               wr_req_i,
  output logic [STRAP_W-1:0] pll_cfg_o,
  output logic               init_done_o,
  output logic               sub_clk_en_o,
  output logic               wr_accept_o,
  output logic               wr_reject_o,
  output logic               wr_err_o
);

  localparam int unsigned INIT_CYCLES = cycles_for(CLK_HZ, INIT_US);

  logic     timer_last;
  logic     clk_en_q;
  wr_resp_t resp;

  strap_latch #(.STRAP_W(STRAP_W)) u_strap (
    .clk    (clk),
    .rst    (rst),
    .pins_i (pll_strap_i),
    .cfg_o  (pll_cfg_o)
  );

  init_timer #(.CYCLES(INIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .done_o (init_done_o),
    .last_o (timer_last)
  );

  write_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .wr_req_i (wr_req_i),
    .done_i   (init_done_o),
    .resp_o   (resp),
    .err_o    (wr_err_o)
  );

  // Clock enable register: opens on the same edge the window completes
  always_ff @(posedge clk) begin
    if (rst) clk_en_q <= 1'b0;
    else     clk_en_q <= init_done_o || timer_last;
  end

  assign sub_clk_en_o = clk_en_q;
  assign wr_accept_o  = resp.accept;
  assign wr_reject_o  = resp.reject;

  AST_GATE_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
    sub_clk_en_o == init_done_o); // R3

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !init_done_o && !sub_clk_en_o && !wr_err_o
                   && !wr_accept_o && !wr_reject_o); // R8

endmodule

// File: tb/sim_init_window_ctrl.sv
module sim_init_window_ctrl;

  localparam int N  = 8;
  localparam int SW = 3;

  typedef struct {
    logic          ready;
    logic          acc;
    logic          rej;
    logic          err;
    logic [SW-1:0] strap;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] strap_pins = '0;
  logic          wr = 1'b0;
  logic [SW-1:0] pll_cfg;
  logic          done, clk_en, acc, rej, err;

  always #2.5 clk = ~clk;

  init_window_ctrl #(.CLK_HZ(1_000_000), .INIT_US(N), .STRAP_W(SW)) u0 (
    .clk          (clk),
    .rst          (rst),
    .pll_strap_i  (strap_pins),
    .wr_req_i     (wr),
    .pll_cfg_o    (pll_cfg),
    .init_done_o  (done),
    .sub_clk_en_o (clk_en),
    .wr_accept_o  (acc),
    .wr_reject_o  (rej),
    .wr_err_o     (err)
  );

  exp_t q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 0;

  // Bench model state
  int            rel_cnt = 0;
  bit            m_err = 0;
  bit            prev_rst = 1;
  logic [SW-1:0] m_strap = 'x;

  task automatic fail(input string what, input string tag, input int got, input int want);
    miscompares++;
    $display("FAIL %s (%s): got %0d expected %0d", what, tag, got, want);
  endtask

  // Driver: sets inputs for the next edge and pushes the expected result
  task automatic step(input bit r, input bit w, input logic [SW-1:0] s, input string tag);
    exp_t e;
    bit ready_before;
    @(negedge clk);
    rst = r; wr = w; strap_pins = s;
    ready_before = (rel_cnt >= N);
    e.acc = !r && w && ready_before;
    e.rej = !r && w && !ready_before;
    if (r) rel_cnt = 0;
    else if (rel_cnt < N + 1) rel_cnt++;
    e.ready = !r && (rel_cnt >= N);
    m_err = r ? 1'b0 : (m_err | e.rej);
    e.err = m_err;
    if (!r && prev_rst) m_strap = s;
    prev_rst = r;
    e.strap = m_strap;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares one expected item just after every edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      vectors++;
      if (done   !== e.ready) fail("R2 init_done",  e.tag, done,   e.ready);
      if (clk_en !== e.ready) fail("R3 sub_clk_en", e.tag, clk_en, e.ready);
      if (acc    !== e.acc)   fail("R4 wr_accept",  e.tag, acc,    e.acc);
      if (rej    !== e.rej)   fail("R5 wr_reject",  e.tag, rej,    e.rej);
      if (err    !== e.err)   fail("R6 wr_err",     e.tag, err,    e.err);
      if (!$isunknown(e.strap) && pll_cfg !== e.strap)
        fail("R1/R7 pll_cfg", e.tag, pll_cfg, e.strap);
    end
  end

  initial begin
    // R8: reset state, writes during reset give no response
    for (int i = 0; i < 3; i++) step(1, 1, 3'd1, "R8 reset");
    // R1: release captures 5
    step(0, 0, 3'd5, "R1 release");
    // R7: pin changes ignored; R5/R6: writes during the window are refused
    step(0, 1, 3'd2, "R5 early write");
    step(0, 0, 3'd7, "R7 pins move");
    step(0, 1, 3'd0, "R5 write");
    for (int i = 0; i < 3; i++) step(0, 0, 3'd4, "R2 counting");
    // Boundary: this request lands at the completion edge, so it is refused
    step(0, 1, 3'd4, "R2 last edge write");
    // R4: now accepted; R6: error stays set
    step(0, 1, 3'd6, "R4 accept");
    step(0, 0, 3'd6, "R6 sticky");
    step(0, 1, 3'd6, "R4 accept again");
    step(0, 0, 3'd6, "R4 idle");
    // R8: reset clears error, done and gate; R7: strap held during reset
    step(1, 0, 3'd1, "R8 reset");
    step(1, 1, 3'd2, "R7 reset hold");
    step(0, 0, 3'd3, "R1 second release");
    for (int i = 0; i < 4; i++) step(0, (i == 2), 3'd0, "R8 partial count");
    // R8: abort mid-count
    step(1, 0, 3'd5, "R8 abort");
    step(1, 0, 3'd5, "R8 abort");
    step(0, 0, 3'd6, "R1 third release");
    for (int i = 0; i < N + 3; i++) step(0, (i == N - 1) || (i == N + 1), 3'd1, "R8 full new window");
    step(0, 0, 3'd1, "tail");
    repeat (3) @(posedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule